// File: doc/BRIEF.md
# Snooping MESI Line Coherence Controller

This block keeps one small direct-mapped data cache coherent with its peers on a shared snooping bus. Each line holds one data word, a tag and one of four coherence states: invalid, shared, exclusive or modified. The processor presents one load or store at a time and holds it until the block acknowledges it. The request completes in the same cycle when the held state allows it. Otherwise the block raises a bus request carrying a read, a read-for-ownership, a data-less upgrade or a victim write-back.

A granted transaction takes one bus cycle. In that cycle the bus model returns the fill word on `bus_rdata_i` and the wired-OR of the other caches' shared responses on `shared_i`. The block then updates the line. The still-held request completes as a hit in the following cycle.

The same block watches transactions from other caches on the snoop port. In the same cycle it answers with a shared indication, and with a flush of the dirty word when it owns the line. The bus places any flushed word in memory before the requester takes its data. A snoop has priority over the processor for that cycle.

Top module: `mesi_coherence_ctrl`

## Requirements
- R1: After reset every line is invalid, so the first access to any address raises a bus request.
- R2: A load that hits a line in modified, exclusive or shared state is acknowledged in the same cycle with the stored word, and no bus request is raised.
- R3: A load miss raises a read (code 1). In the granted cycle the line is filled from `bus_rdata_i`. The line becomes exclusive when `shared_i` is low and shared when it is high. The held load is acknowledged in the next cycle.
- R4: A store to a line in modified or exclusive state completes in the same cycle with no bus request and leaves the line modified, so an exclusive line turns modified silently.
- R5: A store to an invalid line, or to a line whose tag differs and is not modified, raises a read-for-ownership (code 2). In the granted cycle the line is filled and made modified. The store completes in the next cycle.
- R6: A store to a shared line raises a data-less upgrade (code 3). In the granted cycle the line becomes modified and keeps its data. The store completes in the next cycle.
- R7: A miss whose victim line is modified first raises a write-back (code 4) that carries the victim address and word. In the granted cycle the line turns invalid. The fetch for the new address follows.
- R8: A snooped read (code 1) that hits a valid line asserts `snp_shared_o`. A modified line also asserts `snp_flush_o` with its word. Modified and exclusive lines drop to shared.
- R9: A snooped read-for-ownership (code 2) invalidates a hit line and flushes it only when it is modified. A snooped upgrade (code 3) invalidates a hit line without any flush.
- R10: In a cycle with `snp_valid_i` high no processor request is acknowledged or granted. A pending upgrade whose line a snoop invalidates turns into a read-for-ownership.
- R11: `bus_cmd_o` is 0 whenever `bus_req_o` is low. The line index is the low log2(SETS) bits of an address and the tag is the remaining upper bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_req_i | input | 1 | Processor request valid, held until acknowledged |
| cpu_we_i | input | 1 | 1 for store, 0 for load |
| cpu_addr_i | input | ADDR_W | Word address of the request |
| cpu_wdata_i | input | DATA_W | Store data |
| cpu_ack_o | output | 1 | Request completes this cycle |
| cpu_rdata_o | output | DATA_W | Load data, valid with acknowledge |
| bus_req_o | output | 1 | Bus arbitration request |
| bus_gnt_i | input | 1 | Bus grant; the transaction happens in this cycle |
| bus_cmd_o | output | 3 | Transaction code: 0 none, 1 read, 2 read-for-ownership, 3 upgrade, 4 write-back |
| bus_addr_o | output | ADDR_W | Transaction address |
| bus_wdata_o | output | DATA_W | Write-back data |
| bus_rdata_i | input | DATA_W | Fill data from memory or a flushing cache |
| shared_i | input | 1 | Wired-OR shared response of the other caches |
| snp_valid_i | input | 1 | Another cache's transaction is on the bus |
| snp_cmd_i | input | 3 | Snooped transaction code |
| snp_addr_i | input | ADDR_W | Snooped address |
| snp_shared_o | output | 1 | This cache's contribution to the shared line |
| snp_flush_o | output | 1 | This cache supplies the dirty word |
| snp_data_o | output | DATA_W | Flushed word |

## Verification
The bench builds the block with four lines, 8-bit addresses and 16-bit data. With these values addresses 0x10 and 0x20 fall on the same line, and a dirty eviction followed by a refill takes only a few accesses. With four lines, a second address on another line checks that snoops touch only their own index. The narrow data words make the flushed and filled values easy to trace through the memory model. A grant delayed behind a snooped upgrade brings the upgrade-to-ownership conversion within reach.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } line_st_e;

  typedef enum logic [2:0] {
    CMD_NONE = 3'd0,
    CMD_RD   = 3'd1,
    CMD_RDX  = 3'd2,
    CMD_UPGR = 3'd3,
    CMD_WB   = 3'd4
  } bus_cmd_e;
endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter int SETS   = 64,
  parameter int TAG_W  = 10,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  line_st_e          wr_state_i,
  input  logic              wr_tag_en_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic              wr_data_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  a_idx_i,
  output line_st_e          a_state_o,
  output logic [TAG_W-1:0]  a_tag_o,
  output logic [DATA_W-1:0] a_data_o,
  input  logic [IDX_W-1:0]  b_idx_i,
  output line_st_e          b_state_o,
  output logic [TAG_W-1:0]  b_tag_o,
  output logic [DATA_W-1:0] b_data_o
);
  line_st_e          st_a  [SETS];
  logic [TAG_W-1:0]  tag_a [SETS];
  logic [DATA_W-1:0] dat_a [SETS];

  for (genvar g = 0; g < SETS; g++) begin : g_line
    line_st_e          st_q;
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] dat_q;
    logic              sel;

    assign sel = (wr_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              st_q <= ST_I;
      else if (wr_en_i && sel)  st_q <= wr_state_i;
    end

    always_ff @(posedge clk_i) begin
      if (wr_en_i && sel && wr_tag_en_i)  tag_q <= wr_tag_i;
      if (wr_en_i && sel && wr_data_en_i) dat_q <= wr_data_i;
    end

    assign st_a[g]  = st_q;
    assign tag_a[g] = tag_q;
    assign dat_a[g] = dat_q;
  end

  assign a_state_o = st_a[a_idx_i];
  assign a_tag_o   = tag_a[a_idx_i];
  assign a_data_o  = dat_a[a_idx_i];
  assign b_state_o = st_a[b_idx_i];
  assign b_tag_o   = tag_a[b_idx_i];
  assign b_data_o  = dat_a[b_idx_i];
endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
  import mesi_pkg::*;
#(
  parameter int TAG_W  = 10,
  parameter int DATA_W = 32
) (
  input  logic              snp_valid_i,
  input  bus_cmd_e          snp_cmd_i,
  input  logic [TAG_W-1:0]  snp_tag_i,
  input  line_st_e          line_state_i,
  input  logic [TAG_W-1:0]  line_tag_i,
  input  logic [DATA_W-1:0] line_data_i,
  output logic              shared_o,
  output logic              flush_o,
  output logic [DATA_W-1:0] flush_data_o,
  output logic              upd_o,
  output line_st_e          new_state_o
);
  logic hit;
  assign hit = snp_valid_i && (line_state_i != ST_I) && (line_tag_i == snp_tag_i);

  always_comb begin
    shared_o    = 1'b0;
    flush_o     = 1'b0;
    upd_o       = 1'b0;
    new_state_o = line_state_i;
    unique case (snp_cmd_i)
      CMD_RD: begin
        shared_o    = hit;
        flush_o     = hit && (line_state_i == ST_M);
        upd_o       = hit && (line_state_i inside {ST_M, ST_E});
        new_state_o = ST_S;
      end
      CMD_RDX: begin
        flush_o     = hit && (line_state_i == ST_M);
        upd_o       = hit;
        new_state_o = ST_I;
      end
      CMD_UPGR: begin
        upd_o       = hit;
        new_state_o = ST_I;
      end
      default: ;
    endcase
  end

  assign flush_data_o = flush_o ? line_data_i : '0;
endmodule

// File: rtl/mesi_req_unit.sv
module mesi_req_unit
  import mesi_pkg::*;
#(
  parameter int TAG_W  = 10,
  parameter int IDX_W  = 6,
  parameter int DATA_W = 32,
  localparam int ADDR_W = TAG_W + IDX_W
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  line_st_e          line_state_i,
  input  logic [TAG_W-1:0]  line_tag_i,
  input  logic [DATA_W-1:0] line_data_i,
  input  logic              snoop_busy_i,
  input  logic              gnt_i,
  input  logic              shared_i,
  input  logic [DATA_W-1:0] fill_data_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              bus_req_o,
  output bus_cmd_e          bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              upd_o,
  output line_st_e          upd_state_o,
  output logic              upd_tag_en_o,
  output logic              upd_data_en_o,
  output logic [DATA_W-1:0] upd_data_o
);
  logic hit, dirty_victim, local_ok, granted;

  assign hit          = (line_state_i != ST_I) && (line_tag_i == tag_i);
  assign dirty_victim = (line_state_i == ST_M) && !hit;
  assign local_ok     = req_i && hit && (!we_i || line_state_i inside {ST_M, ST_E});
  assign ack_o        = local_ok && !snoop_busy_i;
  assign rdata_o      = line_data_i;
  assign bus_req_o    = req_i && !local_ok;
  assign granted      = bus_req_o && gnt_i && !snoop_busy_i;

  always_comb begin
    if (!bus_req_o)        bus_cmd_o = CMD_NONE;
    else if (dirty_victim) bus_cmd_o = CMD_WB;
    else if (!we_i)        bus_cmd_o = CMD_RD;
    else if (hit)          bus_cmd_o = CMD_UPGR;
    else                   bus_cmd_o = CMD_RDX;
  end

  assign bus_addr_o  = (bus_cmd_o == CMD_WB) ? {line_tag_i, idx_i} : {tag_i, idx_i};
  assign bus_wdata_o = (bus_cmd_o == CMD_WB) ? line_data_i : '0;

  always_comb begin
    upd_o         = 1'b0;
    upd_state_o   = line_state_i;
    upd_tag_en_o  = 1'b0;
    upd_data_en_o = 1'b0;
    upd_data_o    = fill_data_i;
    if (ack_o && we_i) begin
      upd_o         = 1'b1;
      upd_state_o   = ST_M;
      upd_data_en_o = 1'b1;
      upd_data_o    = wdata_i;
    end else if (granted) begin
      upd_o = 1'b1;
      unique case (bus_cmd_o)
        CMD_WB:   upd_state_o = ST_I;
        CMD_RD: begin
          upd_state_o   = shared_i ? ST_S : ST_E;
          upd_tag_en_o  = 1'b1;
          upd_data_en_o = 1'b1;
        end
        CMD_RDX: begin
          upd_state_o   = ST_M;
          upd_tag_en_o  = 1'b1;
          upd_data_en_o = 1'b1;
        end
        CMD_UPGR: upd_state_o = ST_M;
        default:  upd_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/mesi_coherence_ctrl.sv
module mesi_coherence_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SETS   = 64,
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ack_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic [2:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              shared_i,
  input  logic              snp_valid_i,
  input  logic [2:0]        snp_cmd_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              snp_shared_o,
  output logic              snp_flush_o,
  output logic [DATA_W-1:0] snp_data_o
);
  logic [IDX_W-1:0]  c_idx, s_idx;
  logic [TAG_W-1:0]  c_tag, s_tag;
  line_st_e          c_state, s_state;
  logic [TAG_W-1:0]  c_ltag, s_ltag;
  logic [DATA_W-1:0] c_ldata, s_ldata;

  logic              s_upd;
  line_st_e          s_new;
  logic              r_upd, r_tag_en, r_data_en;
  line_st_e          r_state;
  logic [DATA_W-1:0] r_data;
  bus_cmd_e          r_cmd;

  logic              w_en, w_tag_en, w_data_en;
  logic [IDX_W-1:0]  w_idx;
  line_st_e          w_state;

  assign c_idx = cpu_addr_i[IDX_W-1:0];
  assign c_tag = cpu_addr_i[ADDR_W-1:IDX_W];
  assign s_idx = snp_addr_i[IDX_W-1:0];
  assign s_tag = snp_addr_i[ADDR_W-1:IDX_W];

  // snoop owns the single write port in its cycle
  assign w_en      = s_upd || r_upd;
  assign w_idx     = s_upd ? s_idx : c_idx;
  assign w_state   = s_upd ? s_new : r_state;
  assign w_tag_en  = !s_upd && r_tag_en;
  assign w_data_en = !s_upd && r_data_en;

  mesi_line_store #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (w_en),
    .wr_idx_i     (w_idx),
    .wr_state_i   (w_state),
    .wr_tag_en_i  (w_tag_en),
    .wr_tag_i     (c_tag),
    .wr_data_en_i (w_data_en),
    .wr_data_i    (r_data),
    .a_idx_i      (c_idx),
    .a_state_o    (c_state),
    .a_tag_o      (c_ltag),
    .a_data_o     (c_ldata),
    .b_idx_i      (s_idx),
    .b_state_o    (s_state),
    .b_tag_o      (s_ltag),
    .b_data_o     (s_ldata)
  );

  mesi_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
    .snp_valid_i  (snp_valid_i),
    .snp_cmd_i    (bus_cmd_e'(snp_cmd_i)),
    .snp_tag_i    (s_tag),
    .line_state_i (s_state),
    .line_tag_i   (s_ltag),
    .line_data_i  (s_ldata),
    .shared_o     (snp_shared_o),
    .flush_o      (snp_flush_o),
    .flush_data_o (snp_data_o),
    .upd_o        (s_upd),
    .new_state_o  (s_new)
  );

  mesi_req_unit #(.TAG_W(TAG_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_req (
    .req_i         (cpu_req_i),
    .we_i          (cpu_we_i),
    .tag_i         (c_tag),
    .idx_i         (c_idx),
    .wdata_i       (cpu_wdata_i),
    .line_state_i  (c_state),
    .line_tag_i    (c_ltag),
    .line_data_i   (c_ldata),
    .snoop_busy_i  (snp_valid_i),
    .gnt_i         (bus_gnt_i),
    .shared_i      (shared_i),
    .fill_data_i   (bus_rdata_i),
    .ack_o         (cpu_ack_o),
    .rdata_o       (cpu_rdata_o),
    .bus_req_o     (bus_req_o),
    .bus_cmd_o     (r_cmd),
    .bus_addr_o    (bus_addr_o),
    .bus_wdata_o   (bus_wdata_o),
    .upd_o         (r_upd),
    .upd_state_o   (r_state),
    .upd_tag_en_o  (r_tag_en),
    .upd_data_en_o (r_data_en),
    .upd_data_o    (r_data)
  );

  assign bus_cmd_o = r_cmd;
endmodule

// File: rtl/mesi_coherence_chk.sv
module mesi_coherence_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_req_i,
  input logic              cpu_we_i,
  input logic [ADDR_W-1:0] cpu_addr_i,
  input logic              cpu_ack_o,
  input logic              bus_req_o,
  input logic              bus_gnt_i,
  input logic [2:0]        bus_cmd_o,
  input logic              snp_valid_i,
  input logic [2:0]        snp_cmd_i,
  input logic [ADDR_W-1:0] snp_addr_i,
  input logic              snp_shared_o,
  input logic              snp_flush_o
);
  a_r2_ack_no_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ack_o |-> !bus_req_o);

  a_r10_snoop_blocks_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_valid_i |-> !cpu_ack_o);

  // R3 R5 R6: a granted fetch or upgrade lets the held request hit next cycle
  a_r3_fill_then_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_gnt_i && !snp_valid_i && bus_cmd_o inside {3'd1, 3'd2, 3'd3})
    |=> (!cpu_req_i || snp_valid_i || !$stable(cpu_addr_i) || !$stable(cpu_we_i) || cpu_ack_o));

  a_r7_wb_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_gnt_i && !snp_valid_i && bus_cmd_o == 3'd4)
    |=> !(bus_req_o && bus_cmd_o == 3'd4 && $stable(cpu_addr_i)));

  a_r8_read_snoop_demotes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_valid_i && snp_cmd_i == 3'd1 && snp_shared_o)
    |=> !(snp_valid_i && snp_cmd_i == 3'd1 && $stable(snp_addr_i) && snp_flush_o));

  a_r8_flush_on_read_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_flush_o |-> (snp_valid_i && snp_cmd_i inside {3'd1, 3'd2}));

  a_r9_invalidate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_valid_i && snp_cmd_i inside {3'd2, 3'd3})
    |=> !(snp_valid_i && $stable(snp_addr_i) && (snp_shared_o || snp_flush_o)));

  a_r11_cmd_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_req_o |-> (bus_cmd_o == 3'd0));

  a_r11_cmd_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> (bus_cmd_o inside {3'd1, 3'd2, 3'd3, 3'd4}));
endmodule

bind mesi_coherence_ctrl mesi_coherence_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cpu_req_i    (cpu_req_i),
  .cpu_we_i     (cpu_we_i),
  .cpu_addr_i   (cpu_addr_i),
  .cpu_ack_o    (cpu_ack_o),
  .bus_req_o    (bus_req_o),
  .bus_gnt_i    (bus_gnt_i),
  .bus_cmd_o    (bus_cmd_o),
  .snp_valid_i  (snp_valid_i),
  .snp_cmd_i    (snp_cmd_i),
  .snp_addr_i   (snp_addr_i),
  .snp_shared_o (snp_shared_o),
  .snp_flush_o  (snp_flush_o)
);

// File: tb/tb_mesi_coherence_ctrl.sv
module tb_mesi_coherence_ctrl;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int SETS = 4;

  localparam logic [AW-1:0] A_ADR = 8'h10;
  localparam logic [AW-1:0] B_ADR = 8'h20;
  localparam logic [AW-1:0] C_ADR = 8'h05;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          cpu_req = 0, cpu_we = 0, bus_gnt = 0, shared = 0, snp_valid = 0;
  logic [AW-1:0] cpu_addr = '0, snp_addr = '0;
  logic [DW-1:0] cpu_wdata = '0, bus_rdata = '0;
  logic [2:0]    snp_cmd = '0;
  logic          cpu_ack, bus_req, snp_shared, snp_flush;
  logic [DW-1:0] cpu_rdata, bus_wdata, snp_data;
  logic [2:0]    bus_cmd;
  logic [AW-1:0] bus_addr;

  logic          p_req = 0, p_we = 0, p_gnt = 0, p_sh = 0, p_sv = 0;
  logic [AW-1:0] p_addr = '0, p_sa = '0;
  logic [DW-1:0] p_wd = '0;
  logic [2:0]    p_sc = '0;

  int checks = 0;
  int errors = 0;

  int            mst [SETS];
  int            mtg [SETS];
  logic [DW-1:0] mdt [SETS];
  logic [DW-1:0] mem [int];

  mesi_coherence_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SETS(SETS)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_ack_o(cpu_ack), .cpu_rdata_o(cpu_rdata),
    .bus_req_o(bus_req), .bus_gnt_i(bus_gnt), .bus_cmd_o(bus_cmd), .bus_addr_o(bus_addr),
    .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata), .shared_i(shared),
    .snp_valid_i(snp_valid), .snp_cmd_i(snp_cmd), .snp_addr_i(snp_addr),
    .snp_shared_o(snp_shared), .snp_flush_o(snp_flush), .snp_data_o(snp_data)
  );

  function automatic logic [DW-1:0] memrd(int a);
    return mem.exists(a) ? mem[a] : '0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // one clock: drive staged inputs, compare with the model, advance the model
  task automatic cyc();
    int ci, ct, si, st, ecmd, va;
    bit hit, lok, ereq, shit, efl;
    string tg;
    @(negedge clk);
    cpu_req = p_req; cpu_we = p_we; cpu_addr = p_addr; cpu_wdata = p_wd;
    bus_gnt = p_gnt; shared = p_sh; snp_valid = p_sv; snp_cmd = p_sc; snp_addr = p_sa;
    #1;
    bus_rdata = memrd(int'(bus_addr));
    #1;
    ci = int'(p_addr) % SETS; ct = int'(p_addr) / SETS;
    hit  = (mst[ci] != 0) && (mtg[ci] == ct);
    lok  = p_req && hit && (!p_we || mst[ci] >= 2);
    ereq = p_req && !lok;
    va   = mtg[ci] * SETS + ci;
    if (!ereq)                       ecmd = 0;
    else if (mst[ci] == 3 && !hit)   ecmd = 4;
    else if (!p_we)                  ecmd = 1;
    else if (hit)                    ecmd = 3;
    else                             ecmd = 2;
    case (ecmd)
      1: tg = "R3 read request";
      2: tg = "R5 ownership request";
      3: tg = "R6 upgrade request";
      4: tg = "R7 write-back request";
      default: tg = "R11 idle command";
    endcase
    chk(tg, 32'(bus_req), 32'(ereq));
    chk(tg, 32'(bus_cmd), 32'(ecmd));
    if (ereq) chk(tg, 32'(bus_addr), (ecmd == 4) ? 32'(va) : 32'(p_addr));
    if (ecmd == 4) chk("R7 write-back data", 32'(bus_wdata), 32'(mdt[ci]));

    if (p_sv) begin
      si = int'(p_sa) % SETS; st = int'(p_sa) / SETS;
      shit = (mst[si] != 0) && (mtg[si] == st);
      efl  = shit && mst[si] == 3 && (p_sc == 1 || p_sc == 2);
      tg = (p_sc == 1) ? "R8 snoop read" : "R9 snoop invalidate";
      chk("R10 no ack in snoop cycle", 32'(cpu_ack), 0);
      chk(tg, 32'(snp_shared), 32'(shit && p_sc == 1));
      chk(tg, 32'(snp_flush), 32'(efl));
      if (efl) begin
        chk(tg, 32'(snp_data), 32'(mdt[si]));
        mem[int'(p_sa)] = mdt[si];
      end
      if (shit) begin
        if (p_sc == 1 && mst[si] >= 2) mst[si] = 1;
        else if (p_sc == 2 || p_sc == 3) mst[si] = 0;
      end
    end else begin
      chk("R8 snoop quiet", 32'(snp_shared), 0);
      chk("R9 snoop quiet", 32'(snp_flush), 0);
      chk(p_we ? "R4 local store ack" : "R2 local load ack", 32'(cpu_ack), 32'(lok));
      if (lok && !p_we) chk("R2 load data", 32'(cpu_rdata), 32'(mdt[ci]));
      if (lok && p_we) begin
        mdt[ci] = p_wd; mst[ci] = 3;
      end else if (ereq && p_gnt) begin
        case (ecmd)
          4: begin mem[va] = mdt[ci]; mst[ci] = 0; end
          1: begin mst[ci] = p_sh ? 1 : 2; mtg[ci] = ct; mdt[ci] = memrd(int'(p_addr)); end
          2: begin mst[ci] = 3; mtg[ci] = ct; mdt[ci] = memrd(int'(p_addr)); end
          3: mst[ci] = 3;
          default: ;
        endcase
      end
    end
  endtask

  task automatic access(bit we, logic [AW-1:0] a, logic [DW-1:0] wd, bit sh, int gdly,
                        int sat, logic [2:0] sc, logic [AW-1:0] sa);
    bit done = 0;
    p_req = 1; p_we = we; p_addr = a; p_wd = wd; p_sh = sh; p_sc = sc; p_sa = sa;
    for (int n = 0; n < 40 && !done; n++) begin
      p_gnt = (n >= gdly);
      p_sv  = (n == sat);
      cyc();
      if (cpu_ack && !p_sv) done = 1;
    end
    if (!done) begin
      errors++;
      $display("FAIL access timeout addr=%h actual=no-ack expected=ack", a);
    end
    p_req = 0; p_gnt = 0; p_sv = 0; p_sh = 0;
  endtask

  task automatic snoop(logic [2:0] sc, logic [AW-1:0] sa);
    p_sv = 1; p_sc = sc; p_sa = sa;
    cyc();
    p_sv = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < SETS; i++) begin mst[i] = 0; mtg[i] = 0; mdt[i] = '0; end
    mem[int'(A_ADR)] = 16'h1111;
    mem[int'(B_ADR)] = 16'h2222;
    mem[int'(C_ADR)] = 16'h0505;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    cyc();
    chk("R1 reset no request", 32'(bus_req), 0);
    chk("R1 reset no ack", 32'(cpu_ack), 0);

    access(0, A_ADR, '0, 0, 1, -1, 0, '0);        // R1 R3: miss, fill exclusive
    access(0, A_ADR, '0, 0, 0, -1, 0, '0);        // R2 hit
    access(1, A_ADR, 16'hAAAA, 0, 0, -1, 0, '0);  // R4 silent E->M
    snoop(3'd1, A_ADR);                           // R8 flush and demote
    snoop(3'd1, A_ADR);                           // R8 shared, no flush
    access(1, A_ADR, 16'hBBBB, 0, 2, -1, 0, '0);  // R6 upgrade
    access(0, B_ADR, '0, 1, 1, -1, 0, '0);        // R7 write-back, then R3 shared fill
    snoop(3'd2, B_ADR);                           // R9 shared line invalidated
    access(0, A_ADR, '0, 0, 0, -1, 0, '0);        // R7 written-back data returns
    access(1, C_ADR, 16'h1234, 0, 1, -1, 0, '0);  // R5 ownership fill
    snoop(3'd2, C_ADR);                           // R9 flush then invalid
    access(0, C_ADR, '0, 1, 0, -1, 0, '0);        // R3 shared fill
    // R10: snooped upgrade invalidates C while our upgrade waits; it becomes ownership
    access(1, C_ADR, 16'h7777, 0, 3, 1, 3'd3, C_ADR);
    // R10: snoop to an unrelated address delays a hit by one cycle
    access(0, C_ADR, '0, 0, 0, 0, 3'd1, 8'h31);
    snoop(3'd1, C_ADR);                           // R8 modified flush
    snoop(3'd3, C_ADR);                           // R9 upgrade snoop invalidates
    access(0, C_ADR, '0, 0, 0, -1, 0, '0);        // miss again after invalidate
    cyc();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule